// File: doc/BRIEF.md
# Byte-Wide SPI Master with Completion and Collision Flags

This block is an 8-bit SPI master peripheral. A CPU reaches it through a small register bus that has three registers: control, status and data. A write to the data register while the block is an enabled master starts a transfer. The block then generates SCK from the system clock at one of eight rates. It shifts the byte out on MOSI with the most significant bit first and captures MISO on each rising SCK edge (clock idles low). When the transfer ends, the received byte can be read back from the data register.

Completion sets a flag and can raise an interrupt. The flags clear in one of two ways: through a status read followed by a data-register access, or through an interrupt-acknowledge pulse. If the data register is written during a transfer, the block flags a collision and does not disturb the byte in flight. If the slave-select pin is configured as an input and is pulled low while the block is an enabled master, the block treats it as a mode fault: it sets the completion flag, drops out of master mode and aborts any transfer.

The register bus is a plain single-cycle port. Writes take effect at the clock edge where `bus_wr` is high, and `bus_rdata` is valid combinationally in the same cycle as `bus_rd`. The bus has no stream data path, so it has no valid/ready handshake and no back-pressure.

Top module: `sbm_top`

## Requirements
- R1: The rate code is {status bit 0, control bits 1:0}. Codes 0 to 7 make one SCK period last 4, 16, 64, 128, 2, 8, 32 and 64 system clocks. A full byte therefore takes 8 SCK periods from the data write to the completion flag, and code 4 gives the 2-clock minimum.
- R2: When control bit 4 (master) or bit 6 (enable) is clear, the rate code has no effect. A data write only loads the data register, and SCK stays low.
- R3: A transfer shifts the written byte out on MOSI, most significant bit first, and samples MISO on each rising SCK edge. Afterwards the data register reads back the byte received.
- R4: The completion flag is status bit 7. It sets when a transfer finishes. `irq` is high while this flag and control bit 7 (interrupt enable) are both set.
- R5: The collision flag is status bit 6. It sets when the data register is written during a transfer. That write is ignored, and the byte in flight is sent unchanged.
- R6: Reading status while a flag is set arms a clear. The next data-register read or write then clears both flags. A data access that is not armed clears nothing.
- R7: A one-cycle `irq_ack` pulse clears the completion flag and leaves the collision flag unchanged.
- R8: A mode fault sets the completion flag, clears the master bit in control and stops SCK at once. A mode fault occurs when the block is an enabled master, `ss_is_input` is high, and `ss_n` is low after a two-flop synchronizer.
- R9: All registers reset to 0x00. Status bits 5:1 read zero and bit 0 is read/write. Control keeps only bits 7, 6, 4, 1 and 0, and its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status read arms the flag clear) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge, clears completion flag |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Slave-select pin level (asynchronous) |
| ss_is_input | input | 1 | High when the slave-select pin is configured as an input |

## Verification
All eight rate codes are run with different transmit and receive byte pairs. This separates an error in the divider, which shows up as the wrong clock count to completion, from a bit-order or sampling-edge error, which shows up as wrong bytes at either end. The flag handshake is exercised in three orders: data access without a prior status read, status read followed by data access, and acknowledge while a collision is pending. These tell an armed clear apart from an unconditional one, and show which flags each path clears. A slow transfer is interrupted by a slave-select fault to separate abort and demotion from a plain completion. A non-master write is used to show that the rate bits have no effect outside master mode.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam int CB_IRQEN = 7;
  localparam int CB_EN    = 6;
  localparam int CB_MSTR  = 4;

  localparam int HALF_W = 7;

  // Half of one SCK period in system clocks, per rate code.
  function automatic logic [HALF_W-1:0] half_len(input logic [2:0] code);
    case (code)
      3'd0:    half_len = 7'd2;
      3'd1:    half_len = 7'd8;
      3'd2:    half_len = 7'd32;
      3'd3:    half_len = 7'd64;
      3'd4:    half_len = 7'd1;
      3'd5:    half_len = 7'd4;
      3'd6:    half_len = 7'd16;
      default: half_len = 7'd32;
    endcase
  endfunction
endpackage

// File: rtl/sbm_rate_gen.sv
module sbm_rate_gen
  import sbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] lim;

  assign lim  = half_len(code) - HALF_W'(1);
  assign tick = run && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run || cnt >= lim)  cnt <= '0;
    else                          cnt <= cnt + HALF_W'(1);
  end

  // R1: every half-period boundary restarts the count
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
endmodule

// File: rtl/sbm_shifter.sv
module sbm_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              go,
  input  logic              abort,
  input  logic [DATA_W-1:0] load_val,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] shreg_q,
  output logic              done_evt
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] bit_cnt;
  logic             rx_bit;

  assign mosi     = shreg_q[DATA_W-1];
  assign done_evt = busy && tick && sck && (bit_cnt == LAST) && !abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q <= '0;
      busy    <= 1'b0;
      sck     <= 1'b0;
      bit_cnt <= '0;
      rx_bit  <= 1'b0;
    end else if (abort) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      bit_cnt <= '0;
    end else if (load && !busy) begin
      shreg_q <= load_val;
      busy    <= go;
      sck     <= 1'b0;
      bit_cnt <= '0;
    end else if (busy && tick) begin
      if (!sck) begin
        sck    <= 1'b1;
        rx_bit <= miso;
      end else begin
        sck     <= 1'b0;
        shreg_q <= {shreg_q[DATA_W-2:0], rx_bit};
        bit_cnt <= bit_cnt + CNT_W'(1);
        if (bit_cnt == LAST) busy <= 1'b0;
      end
    end
  end

  // R2: no clock activity outside a transfer
  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R3: MOSI only moves on a half-period boundary
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick)) |-> $stable(mosi));
  // R3: the last falling edge ends the transfer
  p_last_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy);
endmodule

// File: rtl/sbm_flags.sv
module sbm_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic done_set,
  input  logic fault_set,
  input  logic coll_set,
  input  logic stat_rd,
  input  logic data_acc,
  input  logic irq_ack,
  output logic done_flag,
  output logic coll_flag
);
  logic armed;
  logic clr;

  assign clr = data_acc && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      done_flag <= 1'b0;
      coll_flag <= 1'b0;
    end else begin
      if (stat_rd && (done_flag || coll_flag)) armed <= 1'b1;
      else if (clr)                            armed <= 1'b0;

      if (done_set || fault_set)  done_flag <= 1'b1;
      else if (clr || irq_ack)    done_flag <= 1'b0;

      if (coll_set)  coll_flag <= 1'b1;
      else if (clr)  coll_flag <= 1'b0;
    end
  end

  p_done_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> done_flag);
  p_coll_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    coll_set |=> coll_flag);
  p_armed_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !done_set && !fault_set && !coll_set) |=> (!done_flag && !coll_flag));
  p_unarmed_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !armed && done_flag && !irq_ack) |=> done_flag);
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !done_set && !fault_set) |=> !done_flag);
endmodule

// File: rtl/sbm_top.sv
module sbm_top
  import sbm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              irq_ack,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  input  logic              ss_n,
  input  logic              ss_is_input
);
  localparam logic [DATA_W-1:0] CTL_MASK =
    DATA_W'((1 << CB_IRQEN) | (1 << CB_EN) | (1 << CB_MSTR) | 3);

  logic [DATA_W-1:0] ctl_q;
  logic              dbl_q;
  logic              ss_meta, ss_sync;
  logic              busy, tick, done_evt;
  logic              done_flag, coll_flag;
  logic [DATA_W-1:0] shreg_q;

  logic wr_ctl, wr_stat, data_wr, stat_rd, data_acc;
  logic is_master, fault, coll_set;

  assign wr_ctl    = bus_wr && (bus_addr == A_CTL);
  assign wr_stat   = bus_wr && (bus_addr == A_STAT);
  assign data_wr   = bus_wr && (bus_addr == A_DATA);
  assign stat_rd   = bus_rd && (bus_addr == A_STAT);
  assign data_acc  = (bus_wr || bus_rd) && (bus_addr == A_DATA);
  assign is_master = ctl_q[CB_EN] && ctl_q[CB_MSTR];
  assign fault     = is_master && ss_is_input && !ss_sync;
  assign coll_set  = data_wr && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ss_meta <= 1'b1;
      ss_sync <= 1'b1;
    end else begin
      ss_meta <= ss_n;
      ss_sync <= ss_meta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      dbl_q <= 1'b0;
    end else begin
      if (wr_ctl)  ctl_q <= bus_wdata & CTL_MASK;
      if (fault)   ctl_q[CB_MSTR] <= 1'b0;
      if (wr_stat) dbl_q <= bus_wdata[0];
    end
  end

  sbm_rate_gen u_rate (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .code ({dbl_q, ctl_q[1:0]}),
    .tick (tick)
  );

  sbm_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (data_wr),
    .go      (is_master),
    .abort   (fault),
    .load_val(bus_wdata),
    .tick    (tick),
    .miso    (miso),
    .busy    (busy),
    .sck     (sck),
    .mosi    (mosi),
    .shreg_q (shreg_q),
    .done_evt(done_evt)
  );

  sbm_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_set (done_evt),
    .fault_set(fault),
    .coll_set (coll_set),
    .stat_rd  (stat_rd),
    .data_acc (data_acc),
    .irq_ack  (irq_ack),
    .done_flag(done_flag),
    .coll_flag(coll_flag)
  );

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = ctl_q;
      A_STAT:  bus_rdata = {done_flag, coll_flag, {(DATA_W-3){1'b0}}, dbl_q};
      A_DATA:  bus_rdata = shreg_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = done_flag && ctl_q[CB_IRQEN];

  // R8: a fault demotes the block and stops the shifter
  p_fault_demote_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !ctl_q[CB_MSTR]);
  p_fault_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!busy && !sck));
  // R5: a colliding write never restarts the shifter
  p_coll_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_set && !fault && !done_evt) |=> busy);
endmodule

// File: tb/sbm_top_tb_top.sv
module sbm_top_tb_top;
  localparam int PER = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, irq_ack = 1'b0;
  logic       sck, mosi, miso;
  logic       ss_n = 1'b1, ss_is_input = 1'b0;

  int tests = 0, fails = 0;

  // vector: [18:16] rate code, [15:8] byte sent, [7:0] byte returned by slave
  localparam logic [23:0] VECS [8] = '{
    24'h00A53C, 24'h0180FF, 24'h02137E, 24'h0301C8,
    24'h04FF00, 24'h05698B, 24'h06E71A, 24'h07524D
  };

  always #(PER/2) clk = ~clk;

  sbm_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .irq_ack(irq_ack), .sck(sck), .mosi(mosi), .miso(miso),
    .ss_n(ss_n), .ss_is_input(ss_is_input)
  );

  // Slave model: presents slv_byte MSB first, shifts on falling SCK, captures on rising.
  logic [7:0] slv_byte = 8'h00;
  logic [7:0] slv_rx;
  logic [3:0] slv_idx;
  logic       slv_rst = 1'b0;

  always @(negedge sck or posedge slv_rst)
    if (slv_rst) slv_idx <= 4'd0;
    else         slv_idx <= slv_idx + 4'd1;

  always @(posedge sck or posedge slv_rst)
    if (slv_rst) slv_rx <= 8'h00;
    else         slv_rx <= {slv_rx[6:0], mosi};

  assign miso = (slv_idx < 4'd8) ? slv_byte[3'(4'd7 - slv_idx)] : 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #(PER/4) d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic slave_prep(input logic [7:0] b);
    slv_byte = b;
    slv_rst = 1'b1; #1; slv_rst = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic int exp_cycles(input logic [2:0] code);
    case (code)
      3'd0: return 32;   3'd1: return 128;
      3'd2: return 512;  3'd3: return 1024;
      3'd4: return 16;   3'd5: return 64;
      3'd6: return 256;  default: return 512;
    endcase
  endfunction

  initial begin
    #(PER * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int n, highs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    bus_read(2'd0, rd); chk("R9 ctl reset", rd, 8'h00);
    bus_read(2'd1, rd); chk("R9 stat reset", rd, 8'h00);
    bus_read(2'd2, rd); chk("R9 data reset", rd, 8'h00);
    chk("R4 irq reset", irq, 1'b0);
    chk("R2 sck reset", sck, 1'b0);

    // Table: every rate code, distinct byte pairs
    foreach (VECS[i]) begin
      logic [2:0] code;
      code = VECS[i][18:16];
      slave_prep(VECS[i][7:0]);
      bus_write(2'd1, {7'b0, code[2]});
      bus_write(2'd0, 8'hD0 | {6'b0, code[1:0]});
      bus_write(2'd2, VECS[i][15:8]);
      wait_irq(n);
      chk("R1 cycles to completion", n, exp_cycles(code));
      chk("R3 slave captured", slv_rx, VECS[i][15:8]);
      bus_read(2'd1, rd); chk("R4 done flag", rd, 8'h80 | {7'b0, code[2]});
      bus_read(2'd2, rd); chk("R3 master received", rd, VECS[i][7:0]);
      bus_read(2'd1, rd); chk("R6 flags cleared", rd, {7'b0, code[2]});
      chk("R4 irq low after clear", irq, 1'b0);
    end

    // R9 register layout
    bus_write(2'd1, 8'hFF); bus_read(2'd1, rd); chk("R9 stat reserved", rd, 8'h01);
    bus_write(2'd1, 8'h00); bus_read(2'd1, rd); chk("R9 stat dbl clear", rd, 8'h00);
    bus_write(2'd0, 8'hFF); bus_read(2'd0, rd); chk("R9 ctl mask", rd, 8'hD3);

    // R2 not master: rate bits ignored, no shifting
    bus_write(2'd0, 8'hC3);
    bus_write(2'd2, 8'h5A);
    highs = 0;
    repeat (200) begin @(negedge clk); if (sck) highs++; end
    chk("R2 sck idle", highs, 0);
    chk("R2 irq idle", irq, 1'b0);
    bus_read(2'd1, rd); chk("R2 no flags", rd, 8'h00);
    bus_read(2'd2, rd); chk("R2 data loaded", rd, 8'h5A);

    // R5 collision
    slave_prep(8'h96);
    bus_write(2'd0, 8'hD0);
    bus_write(2'd2, 8'hC3);
    repeat (4) @(negedge clk);
    bus_write(2'd2, 8'h00);
    wait_irq(n);
    chk("R5 byte in flight kept", slv_rx, 8'hC3);
    bus_read(2'd1, rd); chk("R5 coll and done", rd, 8'hC0);

    // R7 ack clears done only
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R7 irq dropped", irq, 1'b0);
    bus_read(2'd1, rd); chk("R7 coll kept", rd, 8'h40);
    bus_read(2'd2, rd); chk("R3 data after collision", rd, 8'h96);
    bus_read(2'd1, rd); chk("R6 armed clear", rd, 8'h00);

    // R6 unarmed data access clears nothing
    slave_prep(8'h3C);
    bus_write(2'd2, 8'h11);
    wait_irq(n);
    bus_read(2'd2, rd);
    bus_read(2'd1, rd); chk("R6 unarmed keeps done", rd, 8'h80);
    bus_read(2'd2, rd);
    bus_read(2'd1, rd); chk("R6 cleared after arm", rd, 8'h00);

    // R8 mode fault mid transfer
    slave_prep(8'hAA);
    bus_write(2'd0, 8'hD3);
    bus_write(2'd2, 8'hF0);
    repeat (100) @(negedge clk);
    ss_is_input = 1'b1; ss_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 sck stopped", sck, 1'b0);
    chk("R8 irq raised", irq, 1'b1);
    bus_read(2'd0, rd); chk("R8 master cleared", rd, 8'hC3);
    bus_read(2'd1, rd); chk("R8 done set", rd, 8'h80);
    highs = 0;
    repeat (300) begin @(negedge clk); if (sck) highs++; end
    chk("R8 transfer aborted", highs, 0);
    ss_n = 1'b1; ss_is_input = 1'b0;
    bus_read(2'd2, rd);
    bus_read(2'd1, rd); chk("R6 clear after fault", rd, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule